// File: doc/BRIEF.md
# Reverse-Subtract Special-Case Resolver

This unit sits beside the arithmetic datapath of a floating-point reverse subtract, where the result is SRC minus DEST. It receives the class and sign of both operands, a flag saying that the source came from an integer zero, the active rounding mode, and a summary of what the general datapath produced: its sign, its exact-zero indication, its rounded-up bit and its overflow and inexact flags. It does no mantissa arithmetic. It decides whether the datapath result may be used unchanged, whether one operand is copied through, or whether a signed zero, a signed infinity or a NaN must be forced instead. It also produces the exception bits.

The decision is combinational. By default the result is held in an output register, so it appears one clock after the inputs. When an operand is copied, `res_pick` names the operand and `res_sign` gives its final sign. For a NaN result, `res_pick` names the NaN operand to propagate with its quiet bit set, or selects the default NaN (negative, quiet bit set, remaining fraction zero).

Top module: `rsub_special_resolve`

## Requirements
- R1: Operand classes are coded zero=0, finite=1, denormal=2, infinity=3, quiet NaN=4, signalling NaN=5, and 6 or 7 unsupported. `res_sel` codes general=0, zero=1, infinity=2, NaN=3. `res_pick` codes none=0, source=1, destination=2. `res_exc` is {invalid[3], denormal[2], overflow[1], precision[0]}. With two finite nonzero operands and no exact zero, the result is general with pick none, the datapath sign, rounded-up bit, overflow and inexact flags passed through. In every other outcome, bits 1:0 and the rounded-up bit are 0.
- R2: With finite nonzero operands and an exact-zero datapath difference, the result is a forced zero of sign 0, or sign 1 when the rounding mode is 1 (toward minus infinity). Rounding codes are 0 nearest, 1 down, 2 up, 3 toward zero.
- R3: With both operands zero, opposite signs give a zero with the source sign in every rounding mode. Equal signs give the R2 sign rule.
- R4: When `src_int_zero` is 1, the source is treated as +0 whatever its class and sign inputs say.
- R5: Two infinities of equal sign give a NaN result with pick none, sign 1 and the invalid bit set.
- R6: An infinity against any non-NaN operand (finite, zero or an opposite-signed infinity) gives a forced infinity. Its sign is the source sign when the source is infinite, and otherwise the inverted destination sign.
- R7: A zero source with a finite destination gives general, pick destination, with the sign inverted. A zero destination with a finite source gives general, pick source, with the source sign. Neither raises any flag other than denormal.
- R8: Any NaN or unsupported operand gives a NaN result. If either operand is unsupported, the result is the default NaN (pick none, sign 1). Otherwise the source NaN is preferred over the destination NaN, and the picked operand's sign is kept. A signalling NaN or an unsupported operand sets invalid.
- R9: The denormal bit is set when the source is denormal and neither operand is NaN or unsupported. A denormal destination does not set it.
- R10: The outputs are registered. Reset clears all outputs to 0, asynchronously. A new input appears at the outputs on the first rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_cls | input | 3 | Source operand class |
| src_sgn | input | 1 | Source sign |
| src_int_zero | input | 1 | Source came from an integer zero |
| dst_cls | input | 3 | Destination operand class |
| dst_sgn | input | 1 | Destination sign |
| rnd_mode | input | 2 | Rounding mode |
| gen_sign | input | 1 | Sign of the general datapath result |
| gen_rnd_up | input | 1 | Datapath rounded its result up |
| gen_ovf | input | 1 | Datapath overflow |
| gen_inexact | input | 1 | Datapath inexact |
| gen_zero | input | 1 | Datapath difference is exactly zero |
| res_sel | output | 2 | Result source select |
| res_sign | output | 1 | Final result sign |
| res_pick | output | 2 | Copied or propagated operand |
| res_rnd_up | output | 1 | Final rounded-up indication |
| res_exc | output | 4 | Exception bits |

## Verification
The bench builds the block with its default `OUT_REG` of 1. This places the output register under test, so the reset clearing and the one-cycle latency of R10 can be observed at the ports. The vector table covers each class pairing that leads to a distinct forced result. It includes rows where the datapath flags are driven high but must be masked, and a row where an integer-zero source overrides a signalling-NaN class code.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  localparam int CLS_W = 3;
  localparam int RM_W  = 2;
  localparam int EXC_W = 4;
  localparam int EXC_INV = 3;
  localparam int EXC_DEN = 2;
  localparam int EXC_OVF = 1;
  localparam int EXC_PRE = 0;

  typedef enum logic [CLS_W-1:0] {
    CLS_ZERO = 3'd0, CLS_FIN = 3'd1, CLS_DEN = 3'd2, CLS_INF = 3'd3,
    CLS_QNAN = 3'd4, CLS_SNAN = 3'd5, CLS_BAD0 = 3'd6, CLS_BAD1 = 3'd7
  } opclass_e;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR = 2'd0, RM_DOWN = 2'd1, RM_UP = 2'd2, RM_TRUNC = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    SEL_GEN = 2'd0, SEL_ZERO = 2'd1, SEL_INF = 2'd2, SEL_NAN = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0, PICK_SRC = 2'd1, PICK_DST = 2'd2
  } pick_e;

  // Decoded view of one operand
  typedef struct packed {
    logic is_zero;
    logic is_fin;   // finite nonzero, denormals included
    logic is_den;
    logic is_inf;
    logic is_nan;   // quiet or signalling
    logic is_snan;
    logic is_bad;   // unsupported encoding
    logic sgn;
  } opview_t;

  typedef struct packed {
    rsel_e             sel;
    logic              sign;
    pick_e             pick;
    logic              rnd_up;
    logic [EXC_W-1:0]  exc;
  } result_t;

  // Sign of an exact zero produced from operands s and d (s - d)
  function automatic logic exact_zero_sign(logic s_sgn, logic d_sgn, rmode_e rm);
    if (s_sgn != d_sgn) return s_sgn;
    return (rm == RM_DOWN);
  endfunction
endpackage

// File: rtl/rsub_operand_view.sv
module rsub_operand_view
  import rsub_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             sgn,
  input  logic             int_zero,
  output opview_t          view
);
  opclass_e c;
  assign c = opclass_e'(cls);

  always_comb begin
    view         = '0;
    view.is_zero = int_zero | (c == CLS_ZERO);
    view.sgn     = int_zero ? 1'b0 : sgn;
    if (!int_zero) begin
      view.is_fin  = (c == CLS_FIN) | (c == CLS_DEN);
      view.is_den  = (c == CLS_DEN);
      view.is_inf  = (c == CLS_INF);
      view.is_nan  = (c == CLS_QNAN) | (c == CLS_SNAN);
      view.is_snan = (c == CLS_SNAN);
      view.is_bad  = (c == CLS_BAD0) | (c == CLS_BAD1);
    end
  end

  always_comb begin
    if (int_zero) begin
      p_int_zero_pos_r4: assert (view.is_zero && !view.sgn && !view.is_nan && !view.is_bad)
        else $error("integer zero not seen as +0");
    end
    p_one_class: assert ($countones({view.is_zero, view.is_fin, view.is_inf,
                                     view.is_nan, view.is_bad}) == 1)
      else $error("operand view not one-hot");
  end
endmodule

// File: rtl/rsub_resolve_core.sv
module rsub_resolve_core
  import rsub_pkg::*;
(
  input  opview_t s,
  input  opview_t d,
  input  rmode_e  rm,
  input  logic    gen_sign,
  input  logic    gen_rnd_up,
  input  logic    gen_ovf,
  input  logic    gen_inexact,
  input  logic    gen_zero,
  output result_t res
);
  // Named internal events, also used by the assertions below
  logic any_bad, any_nan, nan_case, inf_clash, both_zero, sig_invalid, src_denorm_ev;

  assign any_bad       = s.is_bad | d.is_bad;
  assign any_nan       = s.is_nan | d.is_nan;
  assign nan_case      = any_bad | any_nan;
  assign inf_clash     = s.is_inf & d.is_inf & (s.sgn == d.sgn);
  assign both_zero     = s.is_zero & d.is_zero;
  assign sig_invalid   = any_bad | s.is_snan | d.is_snan | (inf_clash & ~nan_case);
  assign src_denorm_ev = s.is_den & ~nan_case;

  always_comb begin
    res        = '0;
    res.sel    = SEL_GEN;
    res.pick   = PICK_NONE;
    if (nan_case) begin
      res.sel = SEL_NAN;
      if (any_bad) begin
        res.sign = 1'b1;
      end else if (s.is_nan) begin
        res.pick = PICK_SRC;
        res.sign = s.sgn;
      end else begin
        res.pick = PICK_DST;
        res.sign = d.sgn;
      end
    end else if (inf_clash) begin
      res.sel  = SEL_NAN;
      res.sign = 1'b1;
    end else if (s.is_inf) begin
      res.sel  = SEL_INF;
      res.sign = s.sgn;
    end else if (d.is_inf) begin
      res.sel  = SEL_INF;
      res.sign = ~d.sgn;
    end else if (both_zero) begin
      res.sel  = SEL_ZERO;
      res.sign = exact_zero_sign(s.sgn, d.sgn, rm);
    end else if (s.is_zero) begin
      res.pick = PICK_DST;
      res.sign = ~d.sgn;
    end else if (d.is_zero) begin
      res.pick = PICK_SRC;
      res.sign = s.sgn;
    end else if (gen_zero) begin
      res.sel  = SEL_ZERO;
      res.sign = exact_zero_sign(1'b0, 1'b0, rm);
    end else begin
      res.sign          = gen_sign;
      res.rnd_up        = gen_rnd_up;
      res.exc[EXC_OVF]  = gen_ovf;
      res.exc[EXC_PRE]  = gen_inexact;
    end
    res.exc[EXC_INV] = sig_invalid;
    res.exc[EXC_DEN] = src_denorm_ev;
  end

  always_comb begin
    if (res.sel != SEL_GEN || res.pick != PICK_NONE) begin
      p_masked_flags_r1: assert (res.exc[EXC_OVF:EXC_PRE] == 2'b00 && !res.rnd_up)
        else $error("datapath flags leaked into forced result");
    end
    if (both_zero && s.sgn != d.sgn) begin
      p_mixed_zero_sign_r3: assert (res.sel == SEL_ZERO && res.sign == s.sgn)
        else $error("mixed-sign zero difference wrong");
    end
    if (inf_clash && !nan_case) begin
      p_inf_clash_invalid_r5: assert (res.sel == SEL_NAN && res.exc[EXC_INV] && res.pick == PICK_NONE)
        else $error("like-signed infinities not invalid");
    end
    if (res.sel == SEL_NAN && res.pick == PICK_NONE) begin
      p_default_nan_neg_r8: assert (res.sign)
        else $error("default NaN not negative");
    end
    if (nan_case) begin
      p_nan_out_r8: assert (res.sel == SEL_NAN)
        else $error("NaN operand did not give NaN");
    end
    if (res.exc[EXC_DEN]) begin
      p_denorm_src_only_r9: assert (s.is_den && res.sel != SEL_NAN)
        else $error("denormal flag without denormal source");
    end
  end
endmodule

// File: rtl/rsub_out_stage.sv
module rsub_out_stage
  import rsub_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
)(
  input  logic    clk,
  input  logic    rst_n,
  input  result_t d,
  output result_t q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/rsub_special_resolve.sv
module rsub_special_resolve
  import rsub_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_W-1:0] src_cls,
  input  logic             src_sgn,
  input  logic             src_int_zero,
  input  logic [CLS_W-1:0] dst_cls,
  input  logic             dst_sgn,
  input  logic [RM_W-1:0]  rnd_mode,
  input  logic             gen_sign,
  input  logic             gen_rnd_up,
  input  logic             gen_ovf,
  input  logic             gen_inexact,
  input  logic             gen_zero,
  output logic [1:0]       res_sel,
  output logic             res_sign,
  output logic [1:0]       res_pick,
  output logic             res_rnd_up,
  output logic [EXC_W-1:0] res_exc
);
  opview_t s_view, d_view;
  result_t comb_res, held_res;

  rsub_operand_view u_src_view (
    .cls(src_cls), .sgn(src_sgn), .int_zero(src_int_zero), .view(s_view)
  );

  rsub_operand_view u_dst_view (
    .cls(dst_cls), .sgn(dst_sgn), .int_zero(1'b0), .view(d_view)
  );

  rsub_resolve_core u_core (
    .s(s_view), .d(d_view), .rm(rmode_e'(rnd_mode)),
    .gen_sign(gen_sign), .gen_rnd_up(gen_rnd_up), .gen_ovf(gen_ovf),
    .gen_inexact(gen_inexact), .gen_zero(gen_zero), .res(comb_res)
  );

  rsub_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .d(comb_res), .q(held_res)
  );

  assign res_sel    = held_res.sel;
  assign res_sign   = held_res.sign;
  assign res_pick   = held_res.pick;
  assign res_rnd_up = held_res.rnd_up;
  assign res_exc    = held_res.exc;
endmodule

// File: tb/rsub_special_resolve_tb_top.sv
`timescale 1ns/1ps
module rsub_special_resolve_tb_top;
  localparam realtime HALF = 4.0;
  localparam int NV = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] src_cls = '0, dst_cls = '0;
  logic src_sgn = 0, src_int_zero = 0, dst_sgn = 0;
  logic [1:0] rnd_mode = '0;
  logic gen_sign = 0, gen_rnd_up = 0, gen_ovf = 0, gen_inexact = 0, gen_zero = 0;
  logic [1:0] res_sel, res_pick;
  logic res_sign, res_rnd_up;
  logic [3:0] res_exc;

  int checks = 0;
  int fails = 0;

  always #(HALF) clk = ~clk;

  rsub_special_resolve dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_cls(src_cls), .src_sgn(src_sgn), .src_int_zero(src_int_zero),
    .dst_cls(dst_cls), .dst_sgn(dst_sgn), .rnd_mode(rnd_mode),
    .gen_sign(gen_sign), .gen_rnd_up(gen_rnd_up), .gen_ovf(gen_ovf),
    .gen_inexact(gen_inexact), .gen_zero(gen_zero),
    .res_sel(res_sel), .res_sign(res_sign), .res_pick(res_pick),
    .res_rnd_up(res_rnd_up), .res_exc(res_exc)
  );

  // {req, src_cls, src_sgn, int_zero, dst_cls, dst_sgn, rnd, {gsign,grup,govf,ginx,gzero},
  //  exp_sel, exp_sign, exp_pick, exp_rup, exp_exc}
  localparam logic [29:0] VEC [NV] = '{
    {4'd1, 3'd1,1'b0,1'b0, 3'd1,1'b0, 2'd0, 5'b11010, 2'd0,1'b1,2'd0,1'b1,4'b0001}, // R1
    {4'd1, 3'd1,1'b1,1'b0, 3'd1,1'b0, 2'd3, 5'b00110, 2'd0,1'b0,2'd0,1'b0,4'b0011}, // R1
    {4'd2, 3'd1,1'b0,1'b0, 3'd1,1'b0, 2'd0, 5'b11011, 2'd1,1'b0,2'd0,1'b0,4'b0000}, // R2
    {4'd2, 3'd1,1'b0,1'b0, 3'd1,1'b0, 2'd1, 5'b00001, 2'd1,1'b1,2'd0,1'b0,4'b0000}, // R2
    {4'd2, 3'd1,1'b1,1'b0, 3'd1,1'b1, 2'd2, 5'b00001, 2'd1,1'b0,2'd0,1'b0,4'b0000}, // R2
    {4'd3, 3'd0,1'b0,1'b0, 3'd0,1'b1, 2'd1, 5'b00000, 2'd1,1'b0,2'd0,1'b0,4'b0000}, // R3
    {4'd3, 3'd0,1'b1,1'b0, 3'd0,1'b0, 2'd0, 5'b00000, 2'd1,1'b1,2'd0,1'b0,4'b0000}, // R3
    {4'd3, 3'd0,1'b1,1'b0, 3'd0,1'b1, 2'd0, 5'b00000, 2'd1,1'b0,2'd0,1'b0,4'b0000}, // R3
    {4'd3, 3'd0,1'b1,1'b0, 3'd0,1'b1, 2'd1, 5'b00000, 2'd1,1'b1,2'd0,1'b0,4'b0000}, // R3
    {4'd4, 3'd1,1'b1,1'b1, 3'd0,1'b1, 2'd1, 5'b00000, 2'd1,1'b0,2'd0,1'b0,4'b0000}, // R4
    {4'd4, 3'd5,1'b1,1'b1, 3'd1,1'b0, 2'd0, 5'b01010, 2'd0,1'b1,2'd2,1'b0,4'b0000}, // R4
    {4'd5, 3'd3,1'b0,1'b0, 3'd3,1'b0, 2'd0, 5'b00000, 2'd3,1'b1,2'd0,1'b0,4'b1000}, // R5
    {4'd5, 3'd3,1'b1,1'b0, 3'd3,1'b1, 2'd3, 5'b00000, 2'd3,1'b1,2'd0,1'b0,4'b1000}, // R5
    {4'd6, 3'd3,1'b0,1'b0, 3'd3,1'b1, 2'd0, 5'b00000, 2'd2,1'b0,2'd0,1'b0,4'b0000}, // R6
    {4'd6, 3'd1,1'b0,1'b0, 3'd3,1'b0, 2'd0, 5'b01010, 2'd2,1'b1,2'd0,1'b0,4'b0000}, // R6
    {4'd6, 3'd3,1'b1,1'b0, 3'd0,1'b0, 2'd0, 5'b00000, 2'd2,1'b1,2'd0,1'b0,4'b0000}, // R6
    {4'd6, 3'd0,1'b0,1'b0, 3'd3,1'b1, 2'd0, 5'b00000, 2'd2,1'b0,2'd0,1'b0,4'b0000}, // R6
    {4'd7, 3'd1,1'b1,1'b0, 3'd0,1'b0, 2'd0, 5'b01110, 2'd0,1'b1,2'd1,1'b0,4'b0000}, // R7
    {4'd7, 3'd0,1'b0,1'b0, 3'd1,1'b1, 2'd0, 5'b01010, 2'd0,1'b0,2'd2,1'b0,4'b0000}, // R7
    {4'd8, 3'd4,1'b0,1'b0, 3'd1,1'b0, 2'd0, 5'b00000, 2'd3,1'b0,2'd1,1'b0,4'b0000}, // R8
    {4'd8, 3'd5,1'b1,1'b0, 3'd1,1'b0, 2'd0, 5'b00000, 2'd3,1'b1,2'd1,1'b0,4'b1000}, // R8
    {4'd8, 3'd3,1'b0,1'b0, 3'd4,1'b1, 2'd0, 5'b00000, 2'd3,1'b1,2'd2,1'b0,4'b0000}, // R8
    {4'd8, 3'd4,1'b0,1'b0, 3'd6,1'b0, 2'd0, 5'b00000, 2'd3,1'b1,2'd0,1'b0,4'b1000}, // R8
    {4'd8, 3'd4,1'b0,1'b0, 3'd4,1'b1, 2'd0, 5'b00000, 2'd3,1'b0,2'd1,1'b0,4'b0000}, // R8
    {4'd9, 3'd2,1'b0,1'b0, 3'd5,1'b0, 2'd0, 5'b00000, 2'd3,1'b0,2'd2,1'b0,4'b1000}, // R9
    {4'd9, 3'd2,1'b0,1'b0, 3'd1,1'b0, 2'd0, 5'b00010, 2'd0,1'b0,2'd0,1'b0,4'b0101}, // R9
    {4'd9, 3'd1,1'b0,1'b0, 3'd2,1'b0, 2'd0, 5'b00000, 2'd0,1'b0,2'd0,1'b0,4'b0000}, // R9
    {4'd9, 3'd2,1'b1,1'b0, 3'd0,1'b0, 2'd0, 5'b00000, 2'd0,1'b1,2'd1,1'b0,4'b0100}  // R9
  };

  task automatic apply(input logic [29:0] v);
    {src_cls, src_sgn, src_int_zero, dst_cls, dst_sgn, rnd_mode,
     gen_sign, gen_rnd_up, gen_ovf, gen_inexact, gen_zero} = v[25:10];
  endtask

  task automatic expect_out(input string tag, input logic [9:0] exp);
    logic [9:0] got;
    got = {res_sel, res_sign, res_pick, res_rnd_up, res_exc};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got sel=%0d sign=%0b pick=%0d rup=%0b exc=%04b expected sel=%0d sign=%0b pick=%0d rup=%0b exc=%04b",
               tag, got[9:8], got[7], got[6:5], got[4], got[3:0],
               exp[9:8], exp[7], exp[6:5], exp[4], exp[3:0]);
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R10: outputs stay cleared while reset is held, even with a NaN input present
    apply(VEC[20]);
    repeat (3) @(negedge clk);
    expect_out("R10 reset", 10'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R10 after release", VEC[20][9:0]);
    // R10: a new input is not visible before the next rising edge
    apply(VEC[11]);
    #1;
    expect_out("R10 latency hold", VEC[20][9:0]);
    @(negedge clk);
    expect_out("R10 latency update", VEC[11][9:0]);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      expect_out($sformatf("R%0d vector %0d", VEC[i][29:26], i), VEC[i][9:0]);
    end

    // R10: asynchronous reset clears mid-run without a clock edge
    apply(VEC[0]);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    expect_out("R10 async clear", 10'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after async clear", VEC[0][9:0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule